// File: doc/BRIEF.md
# SAR ADC Conversion Phase Sequencer

This block runs a single conversion of a 10-bit charge-redistribution analog-to-digital converter. A command carries a channel number and a 2-bit final-sample-time code. Once the command is taken, the sequencer steps through a short initial sample, a buffered transfer, a programmable direct final sample and a bit-by-bit successive-approximation resolution. Along the way it drives three analog switch controls and the trial code for the DAC array.

All phase timing is counted in pulses of a converter clock-enable input, not in system clocks. This lets the block share one fast clock with the rest of the chip while the analog front end runs at a slower, prescaled rate. When the last bit is settled, the block presents the result code and the channel it belongs to, and pulses a done strobe for one system clock. A synchronous abort drops any conversion in flight.

Top module: `sar_conv_seq`

## Requirements
- R1: A start request is taken only while busy is low and abort is low. A start while busy does not disturb the running conversion. A start with abort in the same idle cycle is ignored.
- R2: Switch controls follow the phase. During initial sample only `samp_en` (channel onto sample capacitor) is high. During transfer only `xfer_en` (buffer drives DAC array) is high. During final sample only `direct_en` (multiplexer charges DAC array directly) is high. During resolution and idle all three are low. The phases occur in exactly that order.
- R3: Initial sample lasts exactly 2 converter-enable pulses and transfer exactly 4.
- R4: Final sample lasts 2, 4, 8 or 16 enable pulses for sample-time codes 00, 01, 10 and 11.
- R5: Resolution lasts 10 enable pulses and works MSB first. The trial code starts at 0x200. Comparator input 1 (input at or above trial) keeps the bit under test, 0 clears it. The result is the binary-search code of the input.
- R6: With the converter enable low, no phase, switch control or trial code changes.
- R7: Total conversion length is 16 plus the final-sample length, 18 to 32 enable pulses.
- R8: Busy rises the cycle after acceptance and falls in the cycle that done rises. Done is high for exactly one system clock, together with the result and the accepted channel.
- R9: Abort during a conversion returns the block to idle on the next edge, with switches low and no done pulse.
- R10: After reset, busy, done, all switch controls, the result and the channel output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cen | input | 1 | Converter clock enable; one pulse is one converter clock |
| start | input | 1 | Conversion request |
| abort | input | 1 | Synchronous abort of the running conversion |
| cmd_chan | input | 5 | Channel number of the command |
| cmd_ist | input | 2 | Final-sample-time code |
| cmp_in | input | 1 | Comparator output, 1 = input at or above trial code |
| busy | output | 1 | Conversion in progress |
| samp_en | output | 1 | Connect channel to sample capacitor |
| xfer_en | output | 1 | Buffered capacitor voltage drives DAC array |
| direct_en | output | 1 | Multiplexer charges DAC array directly |
| dac_code | output | 10 | Trial code for the DAC array |
| done | output | 1 | One-cycle result strobe |
| res_code | output | 10 | Conversion result |
| res_chan | output | 5 | Channel of the result |

## Verification
The assertions assume that `cmd_chan` and `cmd_ist` are only meaningful in the cycle a start is taken, and that `cen`, `start`, `abort` and `cmp_in` may take any value in any cycle. The stall and ordering properties therefore hold whatever the enable pattern is. The bench changes every input half a clock away from the rising edge. It models the comparator as a monotonic threshold against the DAC trial code, so each binary search has one correct answer. It varies the enable rate between every cycle and every third cycle, with one long stall, so the phase lengths are counted in enable pulses and not in clocks.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INIT  = 3'd1,
    PH_XFER  = 3'd2,
    PH_FINAL = 3'd3,
    PH_RES   = 3'd4
  } phase_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  assign last = tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (last)   cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (cnt < limit));
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         cmp,
  output logic [N-1:0] trial,
  output logic [N-1:0] code_fin
);
  localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] mask;

  assign code_fin = (trial & ~mask) | (cmp ? mask : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      trial <= '0;
      mask  <= '0;
    end else if (load) begin
      trial <= TOP_BIT;
      mask  <= TOP_BIT;
    end else if (step) begin
      trial <= code_fin | (mask >> 1);
      mask  <= mask >> 1;
    end
  end

  // R5
  mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask));
  // R5
  step_valid_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (mask != '0));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CH_W      = 5,
  parameter int IST_W     = 2,
  parameter int INIT_CLKS = 2,
  parameter int XFER_CLKS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cen,
  input  logic                start,
  input  logic                abort,
  input  logic [CH_W-1:0]     cmd_chan,
  input  logic [IST_W-1:0]    cmd_ist,
  input  logic                cmp_in,
  output logic                busy,
  output logic                samp_en,
  output logic                xfer_en,
  output logic                direct_en,
  output logic [RES_BITS-1:0] dac_code,
  output logic                done,
  output logic [RES_BITS-1:0] res_code,
  output logic [CH_W-1:0]     res_chan
);
  localparam int FIN_MAX = 2 << ((1 << IST_W) - 1);
  localparam int LEN_MAX = max_of(max_of(FIN_MAX, RES_BITS), max_of(INIT_CLKS, XFER_CLKS));
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  phase_t              ph, ph_nxt;
  logic [CH_W-1:0]     chan_q;
  logic [IST_W-1:0]    ist_q;
  logic [CNT_W-1:0]    limit;
  logic                last, accept, sar_load, sar_step, finish;
  logic [RES_BITS-1:0] code_fin;

  assign accept   = (ph == PH_IDLE) && start && !abort;
  assign sar_load = (ph == PH_FINAL) && last && !abort;
  assign sar_step = (ph == PH_RES) && cen && !abort;
  assign finish   = (ph == PH_RES) && last && !abort;

  always_comb begin
    case (ph)
      PH_INIT:  limit = CNT_W'(INIT_CLKS);
      PH_XFER:  limit = CNT_W'(XFER_CLKS);
      PH_FINAL: limit = CNT_W'(2) << ist_q;
      PH_RES:   limit = CNT_W'(RES_BITS);
      default:  limit = CNT_W'(1);
    endcase
  end

  always_comb begin
    ph_nxt = ph;
    if (ph == PH_IDLE) begin
      if (accept) ph_nxt = PH_INIT;
    end else if (abort) begin
      ph_nxt = PH_IDLE;
    end else if (last) begin
      case (ph)
        PH_INIT:  ph_nxt = PH_XFER;
        PH_XFER:  ph_nxt = PH_FINAL;
        PH_FINAL: ph_nxt = PH_RES;
        default:  ph_nxt = PH_IDLE;
      endcase
    end
  end

  sar_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .clr   ((ph == PH_IDLE) || abort),
    .tick  (cen),
    .limit (limit),
    .last  (last)
  );

  sar_approx_reg #(.N(RES_BITS)) sar_i (
    .clk      (clk),
    .rst      (rst),
    .load     (sar_load),
    .step     (sar_step),
    .cmp      (cmp_in),
    .trial    (dac_code),
    .code_fin (code_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      busy      <= 1'b0;
      samp_en   <= 1'b0;
      xfer_en   <= 1'b0;
      direct_en <= 1'b0;
      chan_q    <= '0;
      ist_q     <= '0;
    end else begin
      ph        <= ph_nxt;
      busy      <= (ph_nxt != PH_IDLE);
      samp_en   <= (ph_nxt == PH_INIT);
      xfer_en   <= (ph_nxt == PH_XFER);
      direct_en <= (ph_nxt == PH_FINAL);
      if (accept) begin
        chan_q <= cmd_chan;
        ist_q  <= cmd_ist;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      res_code <= '0;
      res_chan <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        res_code <= code_fin;
        res_chan <= chan_q;
      end
    end
  end

  // R2
  sw_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({samp_en, xfer_en, direct_en}));
  // R2
  xfer_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_en) |-> $past(samp_en));
  // R2
  direct_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(direct_en) |-> $past(xfer_en));
  // R2
  idle_sw_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(samp_en || xfer_en || direct_en));
  // R1
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !abort) |=> busy);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cen && !abort) |=> ($stable({samp_en, xfer_en, direct_en, busy}) && $stable(dac_code)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && abort) |=> (!busy && !done));
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cen = 1'b0;
  logic       start = 1'b0;
  logic       abort = 1'b0;
  logic [4:0] cmd_chan = '0;
  logic [1:0] cmd_ist = '0;
  logic       cmp_in;
  logic       busy, samp_en, xfer_en, direct_en, done;
  logic [9:0] dac_code, res_code;
  logic [4:0] res_chan;

  logic [9:0] vin = '0;
  int  dv = 1;
  bit  cen_on = 1'b1;
  int  cyc = 0;
  int  nchk = 0, nfail = 0, wd = 0;
  int  tot = 0, n_s = 0, n_x = 0, n_d = 0;

  // columns: sample-time code, channel, input level, enable divider
  localparam int VEC [7][4] = '{
    '{0,  3, 'h000, 1},
    '{1, 17, 'h3FF, 1},
    '{2,  9, 'h155, 2},
    '{3, 31, 'h2AA, 3},
    '{0,  0, 'h200, 1},
    '{3, 12, 'h1FF, 1},
    '{2,  5, 'h001, 2}
  };

  always #4 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  sar_conv_seq dut_i (
    .clk(clk), .rst(rst), .cen(cen), .start(start), .abort(abort),
    .cmd_chan(cmd_chan), .cmd_ist(cmd_ist), .cmp_in(cmp_in),
    .busy(busy), .samp_en(samp_en), .xfer_en(xfer_en), .direct_en(direct_en),
    .dac_code(dac_code), .done(done), .res_code(res_code), .res_chan(res_chan)
  );

  always @(negedge clk) begin
    cyc++;
    cen <= cen_on && ((cyc % dv) == 0);
  end

  always @(posedge clk) begin
    if (busy && cen) begin
      tot <= tot + 1;
      if (samp_en)   n_s <= n_s + 1;
      if (xfer_en)   n_x <= n_x + 1;
      if (direct_en) n_d <= n_d + 1;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: act=%0d exp<=%0d", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int ist, input int ch, input int v, input int div_in, input bit poke);
    int b_t, b_s, b_x, b_d, fin, rs;
    bit seen, pk;
    @(posedge clk);
    dv = div_in;
    @(negedge clk);
    vin = v[9:0];
    cmd_ist = ist[1:0];
    cmd_chan = ch[4:0];
    b_t = tot; b_s = n_s; b_x = n_x; b_d = n_d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    seen = 1'b0; pk = 1'b0;
    for (int k = 0; k < 4000 && !seen; k++) begin
      @(negedge clk);
      if (start) start = 1'b0;
      else if (poke && xfer_en && !pk) begin
        start = 1'b1;
        cmd_chan = ~ch[4:0];
        cmd_ist = ~ist[1:0];
        pk = 1'b1;
      end
      if (done) seen = 1'b1;
    end
    start = 1'b0;
    fin = 2 << ist;
    check(seen, "R8 done seen", seen, 1);
    check(res_code == v[9:0], "R5 result", res_code, v);
    check(res_chan == ch[4:0], "R1/R8 channel", res_chan, ch);
    check(busy == 1'b0, "R8 busy low with done", busy, 0);
    check(n_s - b_s == 2, "R3 initial length", n_s - b_s, 2);
    check(n_x - b_x == 4, "R3 transfer length", n_x - b_x, 4);
    check(n_d - b_d == fin, "R4 final length", n_d - b_d, fin);
    rs = (tot - b_t) - (n_s - b_s) - (n_x - b_x) - (n_d - b_d);
    check(rs == 10, "R5 resolution length", rs, 10);
    check(tot - b_t == 16 + fin, "R7 total length", tot - b_t, 16 + fin);
    check((tot - b_t >= 18) && (tot - b_t <= 32), "R7 range", tot - b_t, 18);
    check(!samp_en && !xfer_en && !direct_en, "R2 switches idle",
          {samp_en, xfer_en, direct_en}, 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done width", done, 0);
  endtask

  initial begin
    logic [12:0] snap;
    bit any_done;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!busy && !done, "R10 busy/done", {busy, done}, 0);
    check(!samp_en && !xfer_en && !direct_en, "R10 switches", {samp_en, xfer_en, direct_en}, 0);
    check(res_code == 0 && res_chan == 0, "R10 result regs", res_code, 0);

    for (int i = 0; i < 7; i++)
      run_conv(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b0);

    // R1 start during conversion is ignored
    run_conv(1, 6, 'h0F0, 1, 1'b1);

    // R1 start with abort while idle is ignored
    @(negedge clk);
    start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    check(busy == 1'b0, "R1 start+abort ignored", busy, 0);

    // R9 abort during final sample
    @(posedge clk); dv = 1;
    @(negedge clk);
    cmd_ist = 2'd3; cmd_chan = 5'd20; vin = 10'h123; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 200 && !direct_en; k++) @(negedge clk);
    check(direct_en == 1'b1, "R9 reached final sample", direct_en, 1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(busy == 1'b0, "R9 busy after abort", busy, 0);
    check(!samp_en && !xfer_en && !direct_en, "R9 switches after abort",
          {samp_en, xfer_en, direct_en}, 0);
    any_done = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (done) any_done = 1'b1;
    end
    check(!any_done, "R9 no done after abort", any_done, 0);
    check(res_chan == 5'd6, "R9 result untouched", res_chan, 6);

    // R6 stall while the enable is held low
    @(negedge clk);
    cmd_ist = 2'd0; cmd_chan = 5'd9; vin = 10'h2C3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 200 && !xfer_en; k++) @(negedge clk);
    @(posedge clk); cen_on = 1'b0;
    @(negedge clk); @(negedge clk);
    snap = {busy, samp_en, xfer_en, dac_code};
    repeat (20) @(negedge clk);
    check({busy, samp_en, xfer_en, dac_code} == snap, "R6 stalled state",
          {busy, samp_en, xfer_en, dac_code}, snap);
    check(busy == 1'b1, "R6 still busy", busy, 1);
    @(posedge clk); cen_on = 1'b1;
    any_done = 1'b0;
    for (int k = 0; k < 400 && !any_done; k++) begin
      @(negedge clk);
      if (done) any_done = 1'b1;
    end
    check(any_done && res_code == 10'h2C3, "R6 result after stall", res_code, 'h2C3);

    // R9 conversion after abort still correct
    run_conv(3, 1, 'h3C5, 1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule